// File: doc/BRIEF.md
# Flash Erase Sequencer

This controller drives the host side of a byte-wide parallel flash bus and runs an erase without help from software. A requester pulses a start line and selects a whole-chip erase or a single-sector erase, giving the sector address. The sequencer then writes the six-word erase command and waits for the flash to finish. It waits either by polling status reads or, when ready mode is selected, by watching the flash ready line. It reports the result as a one-clock done pulse or a one-clock error pulse.

Completion is judged by a toggle bit that goes quiet, not by a single flag. Each status read is compared with the previous one. The flash is finished once the completion bit is set and the toggle bit has not changed between two reads in a row. If the flash raises its time-limit flag first, the sequencer takes two more reads before it calls the erase failed. This settles the case where the flag and the normal finish arrive close together. After a failure the sequencer writes the reset command, so the flash is back in read mode before the next request.

Every bus access drives chip enable and one strobe low for a parameter number of clocks. The address and data stay fixed for the whole strobe, and each access ends with one idle clock.

Top module: `fls_erase_seq`

## Requirements
- R1: While reset is held, busy_o, done_o and err_o are 0, and fl_ce_no, fl_we_no and fl_oe_no are 1.
- R2: A start_i seen while idle makes busy_o 1 on the next clock. chip_i, sect_addr_i and use_rdy_i are captured at that point. A start_i seen while busy changes neither the command writes nor the outcome.
- R3: The erase writes six words, in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55. The sixth word is 0x555/0x10 when chip_i=1, or sect_addr_i/0x30 when chip_i=0. Each pair is address/data.
- R4: Every write holds fl_ce_no and fl_we_no low for exactly STRB_CYC clocks, with fl_addr_o and fl_wdata_o stable. Every read holds fl_ce_no and fl_oe_no low. fl_we_no and fl_oe_no are never low together.
- R5: In poll mode, the status lines are fl_stat_i[2]=bit 7 (complete), fl_stat_i[1]=bit 6 (toggle) and fl_stat_i[0]=bit 5 (time limit). Success is declared only on a read with bit 7=1 whose bit 6 equals bit 6 of the previous read. The first read after the command only sets the reference.
- R6: A read with bit 5=1 that is not a success starts a recheck. The next read sets a new reference and the one after it is judged. If that judged read is a success, done follows; otherwise the erase is failed.
- R7: On failure, the sequencer writes data 0xF0 and then pulses err_o. done_o does not pulse for that request.
- R8: done_o and err_o each last exactly one clock, never occur together, and busy_o is 0 in that clock. Each accepted request gives exactly one of the two.
- R9: With use_rdy_i=1 captured at start, no status read is made while fl_rdy_i is 0. Once fl_rdy_i is 1, one read is made: bit 7=1 gives done, and bit 7=0 takes the failure path of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request an erase |
| chip_i | input | 1 | 1: whole chip, 0: one sector |
| sect_addr_i | input | AW | Sector address for a sector erase |
| use_rdy_i | input | 1 | 1: wait on the ready line instead of polling |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-clock success pulse |
| err_o | output | 1 | One-clock failure pulse |
| fl_addr_o | output | AW | Flash address |
| fl_wdata_o | output | DW | Flash write data |
| fl_stat_i | input | 3 | Flash data bits 7:5 during reads |
| fl_rdy_i | input | 1 | Flash ready line, 1 = ready |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_we_no | output | 1 | Flash write strobe, active low |
| fl_oe_no | output | 1 | Flash read strobe, active low |

## Verification
The time-limit flag and a normal completion can be decided by the same status read, so the two paths meet on one read. The bench provokes this with a flash model that raises bit 5 on one read and reports a quiet, complete status on the next reads. The run is judged by requiring a done pulse, no 0xF0 write, and an exact count of six status reads. In a separate run the flag stays up and the toggle bit keeps moving, and that run must end with the reset write and an error pulse.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_POLL, S_WRDY, S_CONF, S_RST
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_STRB, PH_RCV
  } phy_st_e;

  localparam int unsigned CMD_WORDS = 6;
  localparam logic [7:0] CMD_UNLK_1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK_2 = 8'h55;
  localparam logic [7:0] CMD_SETUP  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

  // index into the 3-bit status slice (data bits 7:5)
  localparam int unsigned ST_CMPL = 2;
  localparam int unsigned ST_TGL  = 1;
  localparam int unsigned ST_TMO  = 0;
endpackage

// File: rtl/fls_bus_phy.sv
module fls_bus_phy
  import fls_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned DW       = 8,
  parameter int unsigned STRB_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          idle_o,
  output logic          ack_o,
  output logic [2:0]    stat_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  input  logic [2:0]    fl_stat_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int unsigned CW = $clog2(STRB_CYC + 1);

  phy_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      stat_q <= '0;
    end else begin
      unique case (st_q)
        PH_IDLE: if (req_i) begin
          st_q   <= PH_STRB;
          cnt_q  <= '0;
          wr_q   <= wr_i;
          addr_q <= addr_i;
          data_q <= wdata_i;
        end
        PH_STRB: begin
          if (cnt_q == CW'(STRB_CYC - 1)) begin
            st_q <= PH_RCV;
            if (!wr_q) stat_q <= fl_stat_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == PH_IDLE);
  assign ack_o      = (st_q == PH_RCV);
  assign stat_o     = stat_q;
  assign fl_addr_o  = addr_q;
  assign fl_wdata_o = data_q;
  assign fl_ce_no   = !(st_q == PH_STRB);
  assign fl_we_no   = !((st_q == PH_STRB) && wr_q);
  assign fl_oe_no   = !((st_q == PH_STRB) && !wr_q);
endmodule

// File: rtl/fls_poll_eval.sv
module fls_poll_eval
  import fls_pkg::*;
(
  input  logic [2:0] cur_i,
  input  logic       prev_tgl_i,
  input  logic       first_i,
  input  logic       recheck_i,
  output logic       complete_o,
  output logic       tmo_o,
  output logic       fail_o
);
  logic judged;

  assign judged     = !first_i;
  assign complete_o = judged && cur_i[ST_CMPL] && (cur_i[ST_TGL] == prev_tgl_i);
  // time-limit flag only opens a recheck; the recheck verdict is final
  assign tmo_o      = judged && !complete_o && !recheck_i && cur_i[ST_TMO];
  assign fail_o     = judged && !complete_o && recheck_i;
endmodule

// File: rtl/fls_erase_seq.sv
module fls_erase_seq
  import fls_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned DW       = 8,
  parameter int unsigned STRB_CYC = 3,
  parameter int unsigned UNLK_A1  = 32'h555,
  parameter int unsigned UNLK_A2  = 32'h2AA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          chip_i,
  input  logic [AW-1:0] sect_addr_i,
  input  logic          use_rdy_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  input  logic [2:0]    fl_stat_i,
  input  logic          fl_rdy_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int unsigned SW = $clog2(CMD_WORDS);
  localparam logic [AW-1:0] A1 = AW'(UNLK_A1);
  localparam logic [AW-1:0] A2 = AW'(UNLK_A2);

  seq_st_e       st_q;
  logic [SW-1:0] step_q;
  logic          chip_q, rdy_mode_q;
  logic [AW-1:0] sa_q;
  logic          prev_tgl_q, first_q, recheck_q;
  logic          done_q, err_q;

  logic          phy_req, phy_wr, phy_idle, phy_ack;
  logic [AW-1:0] phy_addr, cmd_addr;
  logic [DW-1:0] phy_wdata, cmd_data;
  logic [2:0]    phy_stat;
  logic          ev_cmpl, ev_tmo, ev_fail;

  always_comb begin
    unique case (step_q)
      SW'(0): begin cmd_addr = A1; cmd_data = DW'(CMD_UNLK_1); end
      SW'(1): begin cmd_addr = A2; cmd_data = DW'(CMD_UNLK_2); end
      SW'(2): begin cmd_addr = A1; cmd_data = DW'(CMD_SETUP);  end
      SW'(3): begin cmd_addr = A1; cmd_data = DW'(CMD_UNLK_1); end
      SW'(4): begin cmd_addr = A2; cmd_data = DW'(CMD_UNLK_2); end
      default: begin
        cmd_addr = chip_q ? A1 : sa_q;
        cmd_data = chip_q ? DW'(CMD_CHIP) : DW'(CMD_SECT);
      end
    endcase
  end

  assign phy_wr    = (st_q == S_CMD) || (st_q == S_RST);
  assign phy_addr  = (st_q == S_CMD) ? cmd_addr : ((st_q == S_RST) ? '0 : sa_q);
  assign phy_wdata = (st_q == S_RST) ? DW'(CMD_RESET) : cmd_data;
  assign phy_req   = phy_idle && ((st_q == S_CMD) || (st_q == S_POLL) ||
                                  (st_q == S_CONF) || (st_q == S_RST));

  fls_bus_phy #(.AW(AW), .DW(DW), .STRB_CYC(STRB_CYC)) u_phy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (phy_req),
    .wr_i       (phy_wr),
    .addr_i     (phy_addr),
    .wdata_i    (phy_wdata),
    .idle_o     (phy_idle),
    .ack_o      (phy_ack),
    .stat_o     (phy_stat),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o),
    .fl_stat_i  (fl_stat_i),
    .fl_ce_no   (fl_ce_no),
    .fl_we_no   (fl_we_no),
    .fl_oe_no   (fl_oe_no)
  );

  fls_poll_eval u_eval (
    .cur_i      (phy_stat),
    .prev_tgl_i (prev_tgl_q),
    .first_i    (first_q),
    .recheck_i  (recheck_q),
    .complete_o (ev_cmpl),
    .tmo_o      (ev_tmo),
    .fail_o     (ev_fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      step_q     <= '0;
      chip_q     <= 1'b0;
      rdy_mode_q <= 1'b0;
      sa_q       <= '0;
      prev_tgl_q <= 1'b0;
      first_q    <= 1'b1;
      recheck_q  <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q       <= S_CMD;
          step_q     <= '0;
          chip_q     <= chip_i;
          sa_q       <= sect_addr_i;
          rdy_mode_q <= use_rdy_i;
        end
        S_CMD: if (phy_ack) begin
          if (step_q == SW'(CMD_WORDS - 1)) begin
            st_q      <= rdy_mode_q ? S_WRDY : S_POLL;
            first_q   <= 1'b1;
            recheck_q <= 1'b0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        S_POLL: if (phy_ack) begin
          if (ev_cmpl) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else if (ev_fail) begin
            st_q <= S_RST;
          end else if (ev_tmo) begin
            recheck_q <= 1'b1;
            first_q   <= 1'b1;
          end else begin
            prev_tgl_q <= phy_stat[ST_TGL];
            first_q    <= 1'b0;
          end
        end
        S_WRDY: if (fl_rdy_i) st_q <= S_CONF;
        S_CONF: if (phy_ack) begin
          if (phy_stat[ST_CMPL]) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= S_RST;
          end
        end
        S_RST: if (phy_ack) begin
          st_q  <= S_IDLE;
          err_q <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/fls_erase_seq_chk.sv
module fls_erase_seq_chk #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] fl_addr_o,
  input logic [DW-1:0] fl_wdata_o,
  input logic          fl_ce_no,
  input logic          fl_we_no,
  input logic          fl_oe_no
);
  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!busy_o && !done_o && !err_o && fl_ce_no && fl_we_no && fl_oe_no);
    end
  end

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_strobe_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no || !fl_oe_no) |-> !fl_ce_no);

  p_no_rw_clash_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));

  p_wr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_wdata_o)));

  p_err_after_reset_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(fl_wdata_o) == DW'(8'hF0)));

  p_done_one_clk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_one_clk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_result_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));

  p_result_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
endmodule

bind fls_erase_seq fls_erase_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/fls_erase_seq_tb.sv
`timescale 1ns/1ps
module fls_erase_seq_tb;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int STRB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, chip = 1'b0, use_rdy = 1'b0;
  logic [AW-1:0] sa = '0;
  logic busy, done, err, ce_n, we_n, oe_n;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_wdata;
  logic [7:0] f_rdata = 8'h00;
  logic f_rdy = 1'b1;

  fls_erase_seq #(.AW(AW), .DW(DW), .STRB_CYC(STRB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chip_i(chip),
    .sect_addr_i(sa), .use_rdy_i(use_rdy), .busy_o(busy), .done_o(done),
    .err_o(err), .fl_addr_o(f_addr), .fl_wdata_o(f_wdata),
    .fl_stat_i(f_rdata[7:5]), .fl_rdy_i(f_rdy), .fl_ce_no(ce_n),
    .fl_we_no(we_n), .fl_oe_no(oe_n)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // flash model: 0 poll, 1 stuck fail, 2 flag then finish, 3 ready line,
  // 4 ready high but not complete, 5 complete bit early while toggling
  int mode = 0, nb = 0, nf = 0;
  int nwr = 0, rd_idx = 0, rcnt = 0, bad_reads = 0, strobe_bad = 0, we_len = 0, ev_cnt = 0;
  bit armed = 0, prev_we = 1, prev_oe = 1, exp_busy = 0, st_edge = 0, prev_done = 0, prev_err = 0;
  logic [AW-1:0] we_a;
  logic [DW-1:0] we_d;
  logic [AW-1:0] wa[$];
  logic [DW-1:0] wd[$];

  function automatic logic [7:0] tog(input int r);
    return {1'b0, r[0], 6'b0};
  endfunction

  function automatic logic [7:0] status_of(input int r);
    case (mode)
      0: return (r < nb) ? tog(r) : 8'h80;
      1: return (r < nf) ? tog(r) : {1'b0, r[0], 1'b1, 5'b0};
      2: return (r < nf) ? tog(r) : ((r == nf) ? {1'b0, r[0], 1'b1, 5'b0} : 8'h80);
      3: return (rcnt > 0) ? tog(r) : 8'h80;
      4: return tog(r);
      default: return (r < nb) ? tog(r) : ((r < nb + 3) ? {1'b1, r[0], 6'b0} : 8'h80);
    endcase
  endfunction

  always @(posedge clk) st_edge = start;

  always @(negedge clk) begin
    if (!we_n) begin
      if (prev_we) begin
        we_len = 1; we_a = f_addr; we_d = f_wdata;
      end else begin
        we_len++;
        if (f_addr != we_a || f_wdata != we_d) strobe_bad++;
      end
      if (ce_n || !oe_n) strobe_bad++;
    end else if (!prev_we) begin
      if (we_len != STRB) strobe_bad++;
      wa.push_back(we_a); wd.push_back(we_d); nwr++;
      if (we_d == 8'hF0) begin armed = 0; rcnt = 0; end
      else if (nwr == 6) begin armed = 1; rd_idx = 0; rcnt = nb; end
    end
    if (!oe_n) begin
      if (ce_n) strobe_bad++;
      if (mode == 3 && armed && rcnt > 0) bad_reads++;
    end else if (!prev_oe) begin
      rd_idx++;
    end
    prev_we = we_n; prev_oe = oe_n;
    if (mode == 3 && armed && rcnt > 0) rcnt--;
    f_rdata = armed ? status_of(rd_idx) : 8'h00;
    f_rdy = (mode == 3) ? (rcnt == 0) : 1'b1;
    if (rst_n) begin
      if (st_edge && !exp_busy) exp_busy = 1;
      if (done || err) begin exp_busy = 0; ev_cnt++; end
      chk(busy == exp_busy, "R2", "busy trace", busy, exp_busy);
      if (done && prev_done) chk(0, "R8", "done width", 2, 1);
      if (err && prev_err) chk(0, "R8", "err width", 2, 1);
      prev_done = done; prev_err = err;
    end
  end

  task automatic run_op(input bit c, input logic [AW-1:0] a, input bit r, input int m,
                        input int b, input int f, input bit exp_err, input bit poke,
                        input int exp_reads, input string tag);
    int n;
    bit d, e;
    logic [AW-1:0] ea[6];
    logic [DW-1:0] ed[6];
    @(negedge clk);
    mode = m; nb = b; nf = f;
    wa.delete(); wd.delete(); nwr = 0; bad_reads = 0; strobe_bad = 0; ev_cnt = 0;
    @(negedge clk);
    chip = c; sa = a; use_rdy = r; start = 1;
    @(negedge clk);
    start = 0; chip = ~c; sa = ~a; use_rdy = ~r;
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    d = 0; e = 0;
    while (n < 5000) begin
      @(negedge clk);
      if (done || err) begin d = done; e = err; break; end
      n++;
    end
    chk(n < 5000, "R8", {tag, " completion"}, n, 0);
    repeat (20) @(negedge clk);
    chk(d == !exp_err, exp_err ? "R7" : "R5", {tag, " done"}, d, !exp_err);
    chk(e == exp_err, exp_err ? "R7" : "R6", {tag, " err"}, e, exp_err);
    chk(ev_cnt == 1, poke ? "R2" : "R8", {tag, " result count"}, ev_cnt, 1);
    chk(nwr == 6 + exp_err, "R3", {tag, " write count"}, nwr, 6 + exp_err);
    ea = '{20'h555, 20'h2AA, 20'h555, 20'h555, 20'h2AA, c ? 20'h555 : a};
    ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, c ? 8'h10 : 8'h30};
    for (int i = 0; i < 6; i++) begin
      if (i < nwr) begin
        chk(wa[i] == ea[i], "R3", {tag, " write addr"}, wa[i], ea[i]);
        chk(wd[i] == ed[i], "R3", {tag, " write data"}, wd[i], ed[i]);
      end
    end
    if (exp_err && nwr == 7) chk(wd[6] == 8'hF0, "R7", {tag, " reset command"}, wd[6], 8'hF0);
    chk(strobe_bad == 0, "R4", {tag, " strobe timing"}, strobe_bad, 0);
    if (m == 3) chk(bad_reads == 0, "R9", {tag, " reads while not ready"}, bad_reads, 0);
    if (exp_reads >= 0) chk(rd_idx == exp_reads, "R6", {tag, " status reads"}, rd_idx, exp_reads);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R1", "reset outputs", {busy, done, err}, 0);
    chk(ce_n && we_n && oe_n, "R1", "reset strobes", {ce_n, we_n, oe_n}, 3'b111);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run_op(0, 20'h4_0000, 0, 0, 5, 0, 0, 0, 6, "sector poll");
    run_op(1, 20'h0_0000, 0, 0, 2, 0, 0, 1, 4, "chip poll ignored start");
    run_op(0, 20'hF_0000, 0, 0, 0, 0, 0, 0, 2, "already idle");
    run_op(0, 20'h8_0000, 0, 5, 4, 0, 0, 0, 8, "R5 early complete bit");
    run_op(0, 20'h1_0000, 0, 1, 0, 3, 1, 0, 6, "R6 stuck timeout");
    run_op(1, 20'h0_0000, 0, 2, 0, 3, 0, 0, 6, "R6 timeout races finish");
    run_op(0, 20'h2_0000, 1, 3, 40, 0, 0, 0, 1, "R9 ready line");
    run_op(1, 20'h0_0000, 1, 4, 0, 0, 1, 0, 1, "R9 ready not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule